// File: doc/BRIEF.md
# Read-Sequence Unlock Detector

This block watches the accesses made to a memory and turns one exact run of six reads into a command for the array's nonvolatile transfer engine. The strobe `acc_done` marks each finished access, sampled when chip enable releases. The block reads the access kind and the address with it.

Five fixed read addresses must come first. The sixth address picks the command: one value asks for a copy from the working array into the nonvolatile store (save), and another asks for the reverse copy (restore). The chosen command leaves as a single-cycle pulse. The block only observes the bus and never alters an ordinary read or write.

A save is refused while the supply is flagged low. While the transfer engine is busy, nothing is tracked. Any access that breaks the run discards progress, but that access is itself tested as a possible first step.

Top module: `unlock_seq_detector`

## Requirements
- R1: After reset, `save_cmd` and `restore_cmd` are low and progress is empty, so a lone sixth-step read gives no command.
- R2: Reads to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, on six consecutive strobes, raise `save_cmd` in the cycle after the sixth strobe.
- R3: The same five reads followed by a read of 0x0C63 raise `restore_cmd` in the cycle after the sixth strobe.
- R4: Only address bits 13:0 are compared; bit 14 may take any value on any step.
- R5: A write strobe (`acc_write`=1) aborts the run, even to the expected address, and the write never counts as a step.
- R6: A read to an address other than the expected next step aborts the run, and no command follows from the rest of that run.
- R7: The read that aborts a run counts as step one when its address is 0x0E38.
- R8: A save is suppressed when `low_supply` is high at the sixth strobe, and the run is still cleared. A restore is issued regardless of `low_supply`.
- R9: While `xfer_busy` is high, strobes are ignored and progress is cleared.
- R10: Each command pulse lasts exactly one cycle, and progress then returns to empty.
- R11: Cycles without `acc_done` leave progress and outputs unchanged, whatever the address and kind inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_done | input | 1 | One-cycle strobe per completed access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 15 | Address of the completed access |
| low_supply | input | 1 | Supply below save threshold |
| xfer_busy | input | 1 | Transfer engine is running |
| save_cmd | output | 1 | One-cycle save request |
| restore_cmd | output | 1 | One-cycle restore request |

## Verification
Random traffic alone almost never produces six correct reads in a row. The stimulus therefore draws most addresses from the seven key values and strongly favours the step the bench model expects next. The hardest situations are a run broken exactly at the sixth step and a run broken by 0x0E38, which must restart at step one. Both are produced by directed runs and then recur inside the biased random traffic, where bit 14, writes, low supply and busy are flipped at random.

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector #(
  parameter int AW = 15,
  parameter int MW = 14,
  parameter logic [13:0] K0 = 14'h0E38,
  parameter logic [13:0] K1 = 14'h31C7,
  parameter logic [13:0] K2 = 14'h03E0,
  parameter logic [13:0] K3 = 14'h3C1F,
  parameter logic [13:0] K4 = 14'h303F,
  parameter logic [13:0] KSAVE = 14'h0FC0,
  parameter logic [13:0] KREST = 14'h0C63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_done,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic          low_supply,
  input  logic          xfer_busy,
  output logic          save_cmd,
  output logic          restore_cmd
);
  localparam int STEPS = 6;
  localparam int PW = $clog2(STEPS);
  localparam logic [PW-1:0] LAST = PW'(STEPS - 1);

  logic [PW-1:0] pos;
  logic [MW-1:0] key;
  logic [MW-1:0] want;
  logic          unused_hi;

  assign key = acc_addr[MW-1:0];
  assign unused_hi = ^acc_addr[AW-1:MW];

  always_comb begin
    case (pos)
      PW'(0):  want = K0;
      PW'(1):  want = K1;
      PW'(2):  want = K2;
      PW'(3):  want = K3;
      default: want = K4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      save_cmd <= 1'b0;
      restore_cmd <= 1'b0;
    end else begin
      save_cmd <= 1'b0;
      restore_cmd <= 1'b0;
      if (xfer_busy) begin
        pos <= '0;
      end else if (acc_done) begin
        if (acc_write) begin
          pos <= '0;
        end else if (pos == LAST && key == KSAVE) begin
          save_cmd <= !low_supply;
          pos <= '0;
        end else if (pos == LAST && key == KREST) begin
          restore_cmd <= 1'b1;
          pos <= '0;
        end else if (pos != LAST && key == want) begin
          pos <= pos + PW'(1);
        end else begin
          pos <= (key == K0) ? PW'(1) : '0;
        end
      end
    end
  end
endmodule

module unlock_seq_detector_chk #(
  parameter int AW = 15,
  parameter int MW = 14,
  parameter logic [13:0] KSAVE = 14'h0FC0,
  parameter logic [13:0] KREST = 14'h0C63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_done,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic          low_supply,
  input logic          xfer_busy,
  input logic          save_cmd,
  input logic          restore_cmd
);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_cmd && restore_cmd));

  assert_save_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    save_cmd |=> !save_cmd);

  assert_restore_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_cmd |=> !restore_cmd);

  assert_save_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    save_cmd |-> $past(acc_done && !acc_write && !xfer_busy && !low_supply
                       && acc_addr[MW-1:0] == KSAVE));

  assert_restore_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restore_cmd |-> $past(acc_done && !acc_write && !xfer_busy
                          && acc_addr[MW-1:0] == KREST));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!acc_done) |-> !(save_cmd || restore_cmd));

  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_busy) |-> !(save_cmd || restore_cmd));

  assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_write) |-> !(save_cmd || restore_cmd));
endmodule

bind unlock_seq_detector unlock_seq_detector_chk #(
  .AW(AW), .MW(MW), .KSAVE(KSAVE), .KREST(KREST)
) chk (
  .clk(clk), .rst_n(rst_n), .acc_done(acc_done), .acc_write(acc_write),
  .acc_addr(acc_addr), .low_supply(low_supply), .xfer_busy(xfer_busy),
  .save_cmd(save_cmd), .restore_cmd(restore_cmd)
);

// File: tb/unlock_seq_detector_test.sv
`timescale 1ns/1ps
module unlock_seq_detector_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_done = 1'b0;
  logic acc_write = 1'b0;
  logic [14:0] acc_addr = '0;
  logic low_supply = 1'b0;
  logic xfer_busy = 1'b0;
  logic save_cmd, restore_cmd;

  int total = 0;
  int bad = 0;
  int mpos = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  unlock_seq_detector uut (
    .clk(clk), .rst_n(rst_n), .acc_done(acc_done), .acc_write(acc_write),
    .acc_addr(acc_addr), .low_supply(low_supply), .xfer_busy(xfer_busy),
    .save_cmd(save_cmd), .restore_cmd(restore_cmd)
  );

  function automatic logic [13:0] key_at(int i);
    case (i)
      0: return 14'h0E38;
      1: return 14'h31C7;
      2: return 14'h03E0;
      3: return 14'h3C1F;
      4: return 14'h303F;
      5: return 14'h0FC0;
      default: return 14'h0C63;
    endcase
  endfunction

  task automatic check(input string req, input logic act_s, input logic act_r,
                       input logic exp_s, input logic exp_r);
    total++;
    if (act_s !== exp_s || act_r !== exp_r) begin
      bad++;
      $display("FAIL %s save/restore actual=%b%b expected=%b%b", req, act_s, act_r, exp_s, exp_r);
    end
  endtask

  // one strobe, reference model, check the cycle after and the one after that
  task automatic access(input bit wr, input logic [14:0] a, input bit low,
                        input bit busy, input string req);
    logic [13:0] k;
    bit es, er;
    k = a[13:0];
    es = 0; er = 0;
    if (busy) mpos = 0;
    else if (wr) mpos = 0;
    else if (mpos == 5 && k == key_at(5)) begin es = !low; mpos = 0; end
    else if (mpos == 5 && k == key_at(6)) begin er = 1; mpos = 0; end
    else if (mpos != 5 && k == key_at(mpos)) mpos++;
    else mpos = (k == key_at(0)) ? 1 : 0;
    acc_done = 1; acc_write = wr; acc_addr = a; low_supply = low; xfer_busy = busy;
    @(negedge clk);
    acc_done = 0; xfer_busy = 0;
    acc_write = $urandom_range(1); acc_addr = 15'($urandom);
    check(req, save_cmd, restore_cmd, es, er);
    @(negedge clk);
    check({req, " R10 R11"}, save_cmd, restore_cmd, 1'b0, 1'b0);
  endtask

  task automatic run5(input bit hi);
    for (int i = 0; i < 5; i++) access(0, {hi, key_at(i)}, 0, 0, "R2");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", save_cmd, restore_cmd, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    access(0, {1'b0, key_at(5)}, 0, 0, "R1");
    run5(0); access(0, {1'b0, key_at(5)}, 0, 0, "R2");
    run5(0); access(0, {1'b0, key_at(6)}, 0, 0, "R3");
    run5(1); access(0, {1'b1, key_at(6)}, 0, 0, "R4");
    access(0, {1'b1, key_at(0)}, 0, 0, "R4"); access(0, {1'b0, key_at(1)}, 0, 0, "R4");
    access(0, {1'b1, key_at(2)}, 0, 0, "R4"); access(0, {1'b0, key_at(3)}, 0, 0, "R4");
    access(0, {1'b1, key_at(4)}, 0, 0, "R4"); access(0, {1'b1, key_at(5)}, 0, 0, "R4");
    for (int i = 0; i < 3; i++) access(0, {1'b0, key_at(i)}, 0, 0, "R5");
    access(1, {1'b0, key_at(3)}, 0, 0, "R5");
    access(0, {1'b0, key_at(4)}, 0, 0, "R5"); access(0, {1'b0, key_at(5)}, 0, 0, "R5");
    run5(0); access(1, {1'b0, key_at(5)}, 0, 0, "R5");
    access(0, {1'b0, key_at(5)}, 0, 0, "R5");
    run5(0); access(0, 15'h1234, 0, 0, "R6"); access(0, {1'b0, key_at(6)}, 0, 0, "R6");
    for (int i = 0; i < 3; i++) access(0, {1'b0, key_at(i)}, 0, 0, "R6");
    access(0, {1'b0, key_at(4)}, 0, 0, "R6"); access(0, {1'b0, key_at(5)}, 0, 0, "R6");
    for (int i = 0; i < 4; i++) access(0, {1'b0, key_at(i)}, 0, 0, "R7");
    access(0, {1'b0, key_at(0)}, 0, 0, "R7");
    for (int i = 1; i < 6; i++) access(0, {1'b0, key_at(i)}, 0, 0, "R7");
    run5(0); access(0, {1'b0, key_at(5)}, 1, 0, "R8");
    access(0, {1'b0, key_at(6)}, 0, 0, "R8");
    run5(0); access(0, {1'b0, key_at(6)}, 1, 0, "R8");
    for (int i = 0; i < 3; i++) access(0, {1'b0, key_at(i)}, 0, 0, "R9");
    access(0, {1'b0, key_at(3)}, 0, 1, "R9");
    access(0, {1'b0, key_at(4)}, 0, 0, "R9"); access(0, {1'b0, key_at(5)}, 0, 0, "R9");
    run5(0); access(0, {1'b0, key_at(5)}, 0, 1, "R9");
    run5(0); access(0, {1'b0, key_at(6)}, 0, 0, "R10");
    access(0, {1'b0, key_at(6)}, 0, 0, "R10");
    for (int i = 0; i < 3; i++) access(0, {1'b0, key_at(i)}, 0, 0, "R11");
    repeat (7) begin acc_addr = {1'b0, key_at(0)}; @(negedge clk); end
    access(0, {1'b0, key_at(3)}, 0, 0, "R11"); access(0, {1'b0, key_at(4)}, 0, 0, "R11");
    access(0, {1'b0, key_at(6)}, 0, 0, "R11");
    for (int n = 0; n < 4000; n++) begin
      logic [13:0] k;
      int pick;
      pick = $urandom_range(99);
      if (pick < 60) k = key_at(mpos < 5 ? mpos : 5 + $urandom_range(1));
      else if (pick < 90) k = key_at($urandom_range(6));
      else k = 14'($urandom);
      access($urandom_range(19) == 0, {1'($urandom), k}, $urandom_range(9) == 0,
             $urandom_range(29) == 0, "R2 R3 R6 random");
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule